// File: doc/BRIEF.md
# Free-Running Timer with Masked Compare-Clear Interrupt

This block is a 16-bit up counter that advances on an external count-enable strobe. It holds a compare value and raises two interrupt requests. The compare-match interrupt fires when the counter reaches the compare value. The overflow interrupt fires when the counter wraps past its top value. It also fires when a compare match resets the counter, if the clear-on-match mode is selected.

A 3-bit reloading down-counter can hold back the compare-match flag for a set number of matches. With setting N, only every (N+1)th match sets the flag. Both flags are cleared by writing 0 to them. During a read-modify-write access both flags read as 1, so the write-back that follows cannot clear a flag by accident.

Software reaches the block through a small register bus. The bus has a write strobe, a 2-bit address, write data, and a combinational read port.

Address map:
- Address 0 is the control/status word.
- Address 1 is the compare value.
- Address 2 is the live counter value, which is read-only.

Top module: `frt_cmpclr`

## Requirements
- R1: After reset, the control word (address 0), the compare value (address 1) and the counter (address 2) all read 0, and both interrupt outputs are low.
- R2: The counter advances by 1 on each clock where `cnt_en` is high and the stop bit (control bit 5) is 0. Otherwise it holds its value. Writing 1 to control bit 6 sets the counter to 0 on that clock edge. Bit 6 always reads back as 0.
- R3: Clear-on-match mode is off when control bit 4 is 0. In that mode, an advancing cycle at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (control bit 1).
- R4: Clear-on-match mode is on when control bit 4 is 1. In that mode, an advancing cycle where the counter equals the compare value (a match) sets the counter to 0 on that edge and sets the overflow flag.
- R5: The mask setting N sits in control bits 10:8 and drives a down-counter. A match that finds the down-counter non-zero decrements it and leaves the compare flag (control bit 3) unchanged. A match that finds it at zero sets the compare flag and reloads N. With N = 2, the first two matches are masked and the third sets the flag.
- R6: With N = 0, every match sets the compare flag.
- R7: Any write to the control word loads the written N into the down-counter immediately.
- R8: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged.
- R9: While `bus_rmw` is high, control bits 1 and 3 read as 1 whatever the state of the flags.
- R10: `irq_ovf` is the overflow flag AND control bit 0. `irq_cmp` is the compare flag AND control bit 2.
- R11: If a flag is set by hardware and cleared by a write on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-enable strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rmw | input | 1 | Marks a read-modify-write read |
| bus_rdata | output | 16 | Read data (combinational) |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow/clear interrupt request |

## Verification
Each result has a fixed cycle at which it becomes due:
- A register write, a counter step, a flag set, a mask decrement and a flag clear all take effect on the same clock edge that samples the stimulus. They can therefore be read back before the next edge.
- Read data and the RMW override are combinational. They are due in the same cycle the address is driven.

The bench drives all inputs on the falling edge and holds `cnt_en` high for an exact number of rising edges. It samples `bus_rdata` and the interrupt outputs one nanosecond after the falling edge that follows. Each check therefore lands exactly on the edge that produced the result, never one cycle early or late.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int MASK_W  = 3;
    localparam int ADDR_W  = 2;
    localparam int NUM_SRC = 2;

    // interrupt source indices; enable bit is 2*k, flag bit is 2*k+1
    localparam int SRC_OVF = 0;
    localparam int SRC_CMP = 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

    localparam int B_CLR_MODE = 4;
    localparam int B_STOP     = 5;
    localparam int B_TCLR     = 6;
    localparam int B_MASK_LO  = 8;

    typedef struct packed {
        logic               clr_mode;
        logic               stop;
        logic [MASK_W-1:0]  mask_n;
        logic [NUM_SRC-1:0] en;
    } ctrl_t;

endpackage

// File: rtl/frt_count.sv
module frt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             stop,
    input  logic             clr_mode,
    input  logic             clr_req,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    adv;

    always_comb begin
        st_d    = st_q;
        adv     = cnt_en && !stop;
        match_o = adv && (st_q.cnt == cmp_val);
        wrap_o  = adv && (st_q.cnt == TOP);
        if (clr_req) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (clr_mode && match_o) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cnt_en && !stop) && !clr_req) |=> (st_q.cnt == $past(st_q.cnt)));

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !stop && st_q.cnt == TOP) |=> (st_q.cnt == '0));

    // R4
    clear_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !stop && clr_mode && st_q.cnt == cmp_val) |=> (st_q.cnt == '0));

endmodule

// File: rtl/frt_mask.sv
module frt_mask #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         match_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic [W-1:0] reload_i,
    output logic         pass_o
);

    typedef struct packed {
        logic [W-1:0] left;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        pass_o = match_i && (st_q.left == '0);
        if (ld_i) begin
            st_d.left = ld_val_i;
        end else if (match_i) begin
            if (st_q.left == '0) begin
                st_d.left = reload_i;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    masked_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !ld_i && st_q.left != '0) |=> (st_q.left == $past(st_q.left) - W'(1)));

    // R7
    load_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (st_q.left == $past(ld_val_i)));

endmodule

// File: rtl/frt_flags.sv
module frt_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] irq_o
);

    typedef struct packed {
        logic [N-1:0] flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N; k++) begin
            if (set_i[k]) begin
                st_d.flag[k] = 1'b1;
            end else if (clr_i[k]) begin
                st_d.flag[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & en_i;

    for (genvar g = 0; g < N; g++) begin : g_src
        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> st_q.flag[g]);

        // R8
        write_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !st_q.flag[g]);
    end

endmodule

// File: rtl/frt_cmpclr.sv
module frt_cmpclr
    import frt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_rmw,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_cmp,
    output logic              irq_ovf
);

    localparam int DATA_W = CNT_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  cmp;
    } regs_t;

    regs_t               r_d, r_q;
    logic                wr_ctrl;
    logic                tclr;
    logic [CNT_W-1:0]    cnt;
    logic                match_evt;
    logic                wrap_evt;
    logic                cmp_pass;
    logic [NUM_SRC-1:0]  flag_set;
    logic [NUM_SRC-1:0]  flag_clr;
    logic [NUM_SRC-1:0]  flags;
    logic [NUM_SRC-1:0]  irqs;
    logic [DATA_W-1:0]   ctrl_rd;
    logic                unused_wdata;

    // register bank
    always_comb begin
        r_d     = r_q;
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        tclr    = wr_ctrl && bus_wdata[B_TCLR];
        if (wr_ctrl) begin
            r_d.ctrl.clr_mode = bus_wdata[B_CLR_MODE];
            r_d.ctrl.stop     = bus_wdata[B_STOP];
            r_d.ctrl.mask_n   = bus_wdata[B_MASK_LO +: MASK_W];
            for (int k = 0; k < NUM_SRC; k++) begin
                r_d.ctrl.en[k] = bus_wdata[2*k];
            end
        end
        if (bus_wr && (bus_addr == A_CMP)) begin
            r_d.cmp = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign unused_wdata = ^{bus_wdata[DATA_W-1:B_MASK_LO+MASK_W], bus_wdata[7]};

    frt_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .stop     (r_q.ctrl.stop),
        .clr_mode (r_q.ctrl.clr_mode),
        .clr_req  (tclr),
        .cmp_val  (r_q.cmp),
        .cnt_o    (cnt),
        .match_o  (match_evt),
        .wrap_o   (wrap_evt)
    );

    frt_mask #(.W(MASK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match_evt),
        .ld_i     (wr_ctrl),
        .ld_val_i (bus_wdata[B_MASK_LO +: MASK_W]),
        .reload_i (r_q.ctrl.mask_n),
        .pass_o   (cmp_pass)
    );

    always_comb begin
        flag_set[SRC_OVF] = wrap_evt || (r_q.ctrl.clr_mode && match_evt);
        flag_set[SRC_CMP] = cmp_pass;
        for (int k = 0; k < NUM_SRC; k++) begin
            flag_clr[k] = wr_ctrl && !bus_wdata[2*k+1];
        end
    end

    frt_flags #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .en_i   (r_q.ctrl.en),
        .flag_o (flags),
        .irq_o  (irqs)
    );

    assign irq_ovf = irqs[SRC_OVF];
    assign irq_cmp = irqs[SRC_CMP];

    // read path
    always_comb begin
        ctrl_rd = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            ctrl_rd[2*k]   = r_q.ctrl.en[k];
            ctrl_rd[2*k+1] = flags[k] || bus_rmw;
        end
        ctrl_rd[B_CLR_MODE]            = r_q.ctrl.clr_mode;
        ctrl_rd[B_STOP]                = r_q.ctrl.stop;
        ctrl_rd[B_MASK_LO +: MASK_W]   = r_q.ctrl.mask_n;
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_rd;
            A_CMP:   bus_rdata = r_q.cmp;
            A_CNT:   bus_rdata = cnt;
            default: bus_rdata = '0;
        endcase
    end

    // R9
    rmw_reads_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rmw && bus_addr == A_CTRL) |-> (bus_rdata[1] && bus_rdata[3]));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ctrl.en[SRC_CMP] |-> !irq_cmp);

endmodule

// File: tb/frt_cmpclr_tb.sv
module frt_cmpclr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic        bus_rmw = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_cmp;
    logic        irq_ovf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frt_cmpclr u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rmw   (bus_rmw),
        .bus_rdata (bus_rdata),
        .irq_cmp   (irq_cmp),
        .irq_ovf   (irq_ovf)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // mode, stop, N, ovf_en, ovf_flag_wr, cmp_en, cmp_flag_wr, timer clear
    function automatic logic [15:0] cw(input logic m, input logic s, input logic [2:0] n,
                                       input logic oe, input logic of, input logic ce,
                                       input logic cf, input logic tc);
        return {5'd0, n, 1'b0, tc, s, m, cf, ce, of, oe};
    endfunction

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        reg_rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        reg_rd(2'd1, v); chk("R1 cmp", v, 16'h0000);
        reg_rd(2'd2, v); chk("R1 cnt", v, 16'h0000);
        chk("R1 irqs", {14'd0, irq_cmp, irq_ovf}, 16'h0);
    endtask

    task automatic t_count;
        logic [15:0] v;
        reg_wr(2'd1, 16'h0100);
        ticks(5);
        reg_rd(2'd2, v); chk("R2 advance", v, 16'd5);
        repeat (4) @(negedge clk);
        reg_rd(2'd2, v); chk("R2 hold no enable", v, 16'd5);
        reg_wr(2'd0, cw(0, 1, 0, 0, 0, 0, 0, 0));
        ticks(3);
        reg_rd(2'd2, v); chk("R2 stop", v, 16'd5);
        reg_wr(2'd0, cw(0, 0, 0, 0, 0, 0, 0, 1));
        reg_rd(2'd2, v); chk("R2 timer clear", v, 16'd0);
        reg_rd(2'd0, v); chk("R2 clear bit reads 0", v & 16'h0040, 16'h0);
    endtask

    task automatic t_n0;
        logic [15:0] v;
        reg_wr(2'd1, 16'd2);
        reg_wr(2'd0, cw(1, 0, 0, 0, 0, 0, 0, 1));
        ticks(3);
        reg_rd(2'd2, v); chk("R4 cleared on match", v, 16'd0);
        reg_rd(2'd0, v); chk("R4 ovf flag on match clear", {15'd0, v[1]}, 16'd1);
        chk("R6 cmp flag first match", {15'd0, v[3]}, 16'd1);
        reg_wr(2'd0, cw(1, 0, 0, 0, 0, 0, 0, 0));
        ticks(3);
        reg_rd(2'd0, v); chk("R6 cmp flag second match", {15'd0, v[3]}, 16'd1);
    endtask

    task automatic t_flags;
        logic [15:0] v;
        reg_wr(2'd0, cw(1, 0, 0, 0, 1, 0, 1, 0));
        reg_rd(2'd0, v); chk("R8 write 1 keeps", {14'd0, v[3], v[1]}, 16'd3);
        chk("R10 irqs gated off", {14'd0, irq_cmp, irq_ovf}, 16'd0);
        reg_wr(2'd0, cw(1, 0, 0, 1, 1, 1, 1, 0));
        chk("R10 irqs enabled", {14'd0, irq_cmp, irq_ovf}, 16'd3);
        bus_rmw = 1'b1;
        reg_rd(2'd0, v); chk("R9 rmw with flags set", {14'd0, v[3], v[1]}, 16'd3);
        bus_rmw = 1'b0;
        reg_wr(2'd0, cw(1, 0, 0, 1, 0, 1, 0, 0));
        reg_rd(2'd0, v); chk("R8 write 0 clears", {14'd0, v[3], v[1]}, 16'd0);
        chk("R10 irqs follow flags", {14'd0, irq_cmp, irq_ovf}, 16'd0);
        bus_rmw = 1'b1;
        reg_rd(2'd0, v); chk("R9 rmw with flags clear", {14'd0, v[3], v[1]}, 16'd3);
        bus_rmw = 1'b0;
        reg_rd(2'd0, v); chk("R9 plain read", {14'd0, v[3], v[1]}, 16'd0);
    endtask

    task automatic t_mask2;
        logic [15:0] v;
        reg_wr(2'd0, cw(1, 0, 2, 0, 0, 1, 0, 1));
        ticks(3);
        reg_rd(2'd0, v); chk("R5 first match masked", {15'd0, v[3]}, 16'd0);
        chk("R5 irq masked", {15'd0, irq_cmp}, 16'd0);
        ticks(3);
        reg_rd(2'd0, v); chk("R5 second match masked", {15'd0, v[3]}, 16'd0);
        ticks(3);
        reg_rd(2'd0, v); chk("R5 third match sets", {15'd0, v[3]}, 16'd1);
        chk("R5 irq on third", {15'd0, irq_cmp}, 16'd1);
        reg_wr(2'd0, cw(1, 0, 2, 0, 0, 1, 0, 0));
        ticks(6);
        reg_rd(2'd0, v); chk("R5 reload masks again", {15'd0, v[3]}, 16'd0);
        ticks(3);
        reg_rd(2'd0, v); chk("R5 next third sets", {15'd0, v[3]}, 16'd1);
    endtask

    task automatic t_reload;
        logic [15:0] v;
        reg_wr(2'd0, cw(1, 0, 3, 0, 0, 0, 0, 1));
        ticks(3);
        reg_rd(2'd0, v); chk("R7 N=3 masks", {15'd0, v[3]}, 16'd0);
        reg_wr(2'd0, cw(1, 0, 0, 0, 0, 0, 0, 0));
        ticks(3);
        reg_rd(2'd0, v); chk("R7 new N loaded at once", {15'd0, v[3]}, 16'd1);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        ticks(2);
        reg_rd(2'd2, v); chk("R11 setup cnt", v, 16'd2);
        @(negedge clk);
        cnt_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0;
        bus_wdata = cw(1, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        cnt_en = 1'b0; bus_wr = 1'b0;
        reg_rd(2'd0, v); chk("R11 set beats clear", {14'd0, v[3], v[1]}, 16'd3);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        reg_wr(2'd1, 16'h1234);
        reg_wr(2'd0, cw(0, 0, 0, 1, 0, 0, 0, 1));
        ticks(65535);
        reg_rd(2'd2, v); chk("R3 at top", v, 16'hFFFF);
        reg_rd(2'd0, v); chk("R3 no ovf yet", {15'd0, v[1]}, 16'd0);
        ticks(1);
        reg_rd(2'd2, v); chk("R3 wrapped", v, 16'h0000);
        reg_rd(2'd0, v); chk("R3 ovf flag", {15'd0, v[1]}, 16'd1);
        chk("R10 irq_ovf", {15'd0, irq_ovf}, 16'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_n0();
        t_flags();
        t_mask2();
        t_reload();
        t_collide();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule